// File: doc/BRIEF.md
# Three-Channel Reloading Down-Timer

This block holds three independent 32-bit down-counters behind one small register bus. Each channel has a reload constant, a live counter and a control word, and one shared run register gates all three channels. A running channel decrements once per count tick. The count tick comes from one of three sources: the peripheral tick enable divided by a power of four, a real-time-clock tick, or an external tick. The channel's control word selects the source.

When a tick arrives while the counter is at zero, the counter reloads from its constant and a sticky underflow flag is set. Software can only clear that flag. Each channel's interrupt line is high whenever its flag and its interrupt enable are both set. Changing either bit therefore raises or drops the line on the next cycle.

Register map (byte addresses on `bus_addr`): the run register is at 0x04, and channel i owns 0x08+12i (constant), 0x0C+12i (counter) and 0x10+12i (control). Writes take effect at the clock edge. Reads are combinational.

Top module: `tri_down_timer`

## Requirements
- R1: After reset every counter and constant reads 0xFFFFFFFF, every control word and the run register read 0, and all interrupt lines are low.
- R2: Bit i of the run register (address 0x04) enables channel i. While the bit is 0, the channel's counter holds its value whatever ticks arrive.
- R3: Control bits [2:0] codes 0..5 divide the peripheral tick by 4, 16, 64, 256, 1024 and 4096 respectively. A running counter drops by one on every Nth peripheral tick counted from the start, so after K ticks it has dropped by floor(K/N).
- R4: Code 6 counts one step per real-time-clock tick and code 7 counts one step per external tick. The other two tick inputs then have no effect on that channel.
- R5: A count tick that arrives with the counter at 0 loads the constant into the counter and sets the underflow flag (control bit 8). With constant C, successive underflows are C+1 ticks apart.
- R6: A control write can clear the underflow flag by writing 0 to bit 8, but it never sets the flag. Writing 1 to bit 8 leaves the flag unchanged.
- R7: Interrupt line i is high exactly when channel i's flag (bit 8) and interrupt enable (bit 5) are both 1. After a control write the line reflects the new bits in the next cycle.
- R8: A counter write to a running channel loads the value at once and restarts its prescaler phase, so the next decrement needs a full division period.
- R9: Channels are independent. Each has its own prescaler phase, and stimulus to one channel's source leaves the counters of the others unchanged.
- R10: A control word reads back only bits [2:0], 5 and 8, with all other bits 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pclk_tick | input | 1 | Peripheral tick enable, one cycle per tick |
| rtc_tick | input | 1 | Real-time-clock tick |
| ext_tick | input | 1 | External tick |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
On every cycle, the assertions check the following:
- a stopped counter holds its value;
- a tick decrements or reloads the counter;
- the prescaler count stays below its limit;
- a control write never sets the flag;
- clearing the enable drops the line on the next cycle.

Only the bench's scenarios can show:
- the exact division ratio of every prescaler code;
- the phase restart after a counter write;
- the source selection of codes 6 and 7;
- the independence of the channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CW       = 32;
  localparam int PW       = 12;
  localparam int NCH      = 3;
  localparam int F_UNIE   = 5;
  localparam int F_UNF    = 8;
  localparam int ADDR_RUN = 4;
  localparam int ADDR_CH0 = 8;
  localparam int CH_STEP  = 12;

  typedef logic [2:0] rate_t;

  // division ratio of the peripheral tick for codes 0..5
  function automatic logic [PW:0] div_ratio(input rate_t code);
    logic [PW:0] r;
    r = (PW+1)'(4) << (2 * code);
    if (code > 3'd5) r = (PW+1)'(1);
    return r;
  endfunction

  // readable image of a control word
  function automatic logic [CW-1:0] ctl_image(input rate_t code, input logic ie, input logic fl);
    logic [CW-1:0] v;
    v = '0;
    v[2:0]   = code;
    v[F_UNIE] = ie;
    v[F_UNF]  = fl;
    return v;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  en,
  input  rate_t code,
  input  logic  pclk_tick,
  input  logic  rtc_tick,
  input  logic  ext_tick,
  output logic  tick_o
);
  logic [PW:0]   limit;
  logic [PW-1:0] phase;
  logic          wrap;

  assign limit = div_ratio(code);
  assign wrap  = pclk_tick && ({1'b0, phase} == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) phase <= '0;
    else if (en && pclk_tick && code < 3'd6) phase <= wrap ? '0 : phase + 1'b1;
  end

  always_comb begin
    tick_o = 1'b0;
    if (en && !clr) begin
      case (code)
        3'd6:    tick_o = rtc_tick;
        3'd7:    tick_o = ext_tick;
        default: tick_o = wrap;
      endcase
    end
  end

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code < 3'd6 |-> {1'b0, phase} < limit);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start_pulse,
  input  logic          pclk_tick,
  input  logic          rtc_tick,
  input  logic          ext_tick,
  input  logic          wr_const,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] const_q,
  output logic [CW-1:0] ctl_q,
  output logic          irq
);
  rate_t code;
  logic  ie, flag;
  logic  cnt_tick, uflow;

  tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(start_pulse | wr_cnt), .en(run), .code(code),
    .pclk_tick(pclk_tick), .rtc_tick(rtc_tick), .ext_tick(ext_tick), .tick_o(cnt_tick)
  );

  assign uflow = cnt_tick && !wr_cnt && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      const_q <= '1;
    end else begin
      if (wr_const) const_q <= wdata;
      if (wr_cnt)        cnt_q <= wdata;
      else if (uflow)    cnt_q <= const_q;
      else if (cnt_tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      ie   <= 1'b0;
      flag <= 1'b0;
    end else if (wr_ctl) begin
      code <= wdata[2:0];
      ie   <= wdata[F_UNIE];
      flag <= (flag & wdata[F_UNF]) | uflow;
    end else if (uflow) begin
      flag <= 1'b1;
    end
  end

  assign ctl_q = ctl_image(code, ie, flag);
  assign irq   = flag & ie;

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_cnt |=> $stable(cnt_q));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick && !wr_cnt && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uflow && !wr_const |=> cnt_q == $past(const_q) && ctl_q[F_UNF]);
  p_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !ctl_q[F_UNF] && !uflow |=> !ctl_q[F_UNF]);
  p_irq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl && !wdata[F_UNIE] |=> !irq);
endmodule

// File: rtl/tri_down_timer.sv
module tri_down_timer
  import tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [7:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          pclk_tick,
  input  logic          rtc_tick,
  input  logic          ext_tick,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] run;
  logic           wr_run;
  logic [NCH-1:0] start_pulse;
  logic [CW-1:0]  cnt_q   [NCH];
  logic [CW-1:0]  const_q [NCH];
  logic [CW-1:0]  ctl_q   [NCH];
  logic [NCH-1:0] wr_const, wr_cnt, wr_ctl;

  assign wr_run      = bus_wr && bus_addr == 8'(ADDR_RUN);
  assign start_pulse = wr_run ? (bus_wdata[NCH-1:0] & ~run) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (wr_run) run <= bus_wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int BASE = ADDR_CH0 + CH_STEP * i;
    assign wr_const[i] = bus_wr && bus_addr == 8'(BASE);
    assign wr_cnt[i]   = bus_wr && bus_addr == 8'(BASE + 4);
    assign wr_ctl[i]   = bus_wr && bus_addr == 8'(BASE + 8);

    tmr_channel u_ch (
      .clk(clk), .rst_n(rst_n), .run(run[i]), .start_pulse(start_pulse[i]),
      .pclk_tick(pclk_tick), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
      .wr_const(wr_const[i]), .wr_cnt(wr_cnt[i]), .wr_ctl(wr_ctl[i]), .wdata(bus_wdata),
      .cnt_q(cnt_q[i]), .const_q(const_q[i]), .ctl_q(ctl_q[i]), .irq(irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == 8'(ADDR_RUN)) bus_rdata = CW'(run);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == 8'(ADDR_CH0 + CH_STEP * i))     bus_rdata = const_q[i];
      if (bus_addr == 8'(ADDR_CH0 + CH_STEP * i + 4)) bus_rdata = cnt_q[i];
      if (bus_addr == 8'(ADDR_CH0 + CH_STEP * i + 8)) bus_rdata = ctl_q[i];
    end
  end

  p_run_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_run |=> $stable(run));
endmodule

// File: tb/tri_down_timer_test.sv
module tri_down_timer_test;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        pclk_tick = 0, rtc_tick = 0, ext_tick = 0;
  logic [2:0]  irq;
  int total = 0, bad = 0;
  logic done = 0;

  tri_down_timer uut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] a_const(int ch); return 8'(8 + 12*ch); endfunction
  function automatic logic [7:0] a_cnt(int ch);   return 8'(12 + 12*ch); endfunction
  function automatic logic [7:0] a_ctl(int ch);   return 8'(16 + 12*ch); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic pulse(int src, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (src == 0) pclk_tick = 1; else if (src == 1) rtc_tick = 1; else ext_tick = 1;
      @(negedge clk);
      pclk_tick = 0; rtc_tick = 0; ext_tick = 0;
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int div, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int ch = 0; ch < 3; ch++) begin
      rd(a_const(ch), v); chk("R1 const", v, 32'hFFFF_FFFF);
      rd(a_cnt(ch), v);   chk("R1 cnt", v, 32'hFFFF_FFFF);
      rd(a_ctl(ch), v);   chk("R1 ctl", v, 0);
    end
    rd(8'h04, v); chk("R1 run", v, 0);
    chk("R1 irq", 32'(irq), 0);
    // R10 map and masking
    rd(8'h00, v); chk("R10 unmapped", v, 0);
    wr(a_ctl(2), 32'hFFFF_FEF2);
    rd(a_ctl(2), v); chk("R10 ctl mask", v, 32'h22);
    wr(a_ctl(2), 0);
    // R3 prescaler sweep, codes 0..5
    for (int code = 0; code < 6; code++) begin
      div = 4 << (2*code);
      wr(a_ctl(0), 32'(code));
      wr(a_cnt(0), 1000);
      wr(8'h04, 1);
      pulse(0, div - 1);
      rd(a_cnt(0), v); chk($sformatf("R3 code%0d before", code), v, 1000);
      pulse(0, 1);
      rd(a_cnt(0), v); chk($sformatf("R3 code%0d first", code), v, 999);
      pulse(0, div);
      rd(a_cnt(0), v); chk($sformatf("R3 code%0d second", code), v, 998);
      wr(8'h04, 0);
    end
    // R8 counter write restarts phase; R2 freeze
    wr(a_ctl(0), 0);
    wr(8'h04, 1);
    pulse(0, 3);
    wr(a_cnt(0), 100);
    pulse(0, 3);
    rd(a_cnt(0), v); chk("R8 phase restarted", v, 100);
    pulse(0, 1);
    rd(a_cnt(0), v); chk("R8 first step", v, 99);
    wr(8'h04, 0);
    pulse(0, 8);
    rd(a_cnt(0), v); chk("R2 frozen", v, 99);
    // R5 R6 R7 on channel 1, external tick
    wr(a_const(1), 2);
    wr(a_cnt(1), 1);
    wr(a_ctl(1), 32'h27);
    wr(8'h04, 2);
    pulse(2, 1);
    rd(a_cnt(1), v); chk("R5 at zero", v, 0);
    rd(a_ctl(1), v); chk("R5 no flag yet", v, 32'h27);
    chk("R7 irq low", 32'(irq[1]), 0);
    pulse(2, 1);
    rd(a_cnt(1), v); chk("R5 reload", v, 2);
    rd(a_ctl(1), v); chk("R5 flag", v, 32'h127);
    chk("R7 irq high", 32'(irq[1]), 1);
    wr(a_ctl(1), 32'h107);
    chk("R7 enable off", 32'(irq[1]), 0);
    wr(a_ctl(1), 32'h127);
    chk("R7 enable on", 32'(irq[1]), 1);
    wr(a_ctl(1), 32'h027);
    rd(a_ctl(1), v); chk("R6 clear", v, 32'h27);
    chk("R7 clear drops", 32'(irq[1]), 0);
    wr(a_ctl(1), 32'h127);
    rd(a_ctl(1), v); chk("R6 no set", v, 32'h27);
    chk("R6 irq stays low", 32'(irq[1]), 0);
    pulse(2, 2);
    rd(a_ctl(1), v); chk("R5 period before", v, 32'h27);
    pulse(2, 1);
    rd(a_ctl(1), v); chk("R5 period C+1", v, 32'h127);
    rd(a_cnt(1), v); chk("R5 reload again", v, 2);
    // R4 R9 on channel 2, rtc tick
    wr(a_const(2), 5);
    wr(a_cnt(2), 3);
    wr(a_ctl(2), 6);
    wr(8'h04, 6);
    pulse(2, 1);
    rd(a_cnt(2), v); chk("R4 ext ignored by rtc channel", v, 3);
    rd(a_cnt(1), v); chk("R9 ext channel steps", v, 1);
    pulse(1, 1);
    rd(a_cnt(2), v); chk("R4 rtc step", v, 2);
    rd(a_cnt(1), v); chk("R9 rtc ignored by ext channel", v, 1);
    pulse(0, 8);
    rd(a_cnt(2), v); chk("R4 pclk ignored", v, 2);
    rd(a_cnt(0), v); chk("R9 stopped channel", v, 99);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule